// File: doc/BRIEF.md
# Token-Passing Daisy-Chain Readout Controller

This block sits in every chip of a chain that shares a single serial data line towards the acquisition system. After conversion has filled a small local event store, the readout phase begins. A token then travels from chip to chip. A chip that receives the token fetches its stored event words from a local RAM, one after another. It shifts them onto the shared line and drives the line's output enable only for as long as it holds the token. It then releases the line and forwards the token to its neighbour. A chip with nothing stored forwards the token straight away. The chip marked as the tail of the chain raises a completion flag when it hands the token out, and that flag means the whole chain has been read.

Each event word packs a 12-bit bunch-crossing number, a 12-bit charge value, a gain-range bit and a trigger-status bit. The controller treats the word as opaque bits. It reads the RAM through a simple port with one cycle of read latency.

Top module: `tkr_chain_readout`

## Requirements
- R1: While reset is held and in the first cycle after it, tok_out, sdo, sdo_oe, rd_done and ram_rd_en are all 0.
- R2: When tok_in is sampled high with an event count of zero, tok_out is high in the very next cycle and sdo_oe never rises.
- R3: With N > 0 events, sdo_oe rises in the third cycle after the cycle in which tok_in is sampled. Words at RAM addresses 0 to N-1 then appear back to back, in address order, most-significant bit first, one bit per clock. Each word holds bcid in bits 25:14, charge in bits 13:2, gain range in bit 1 and trigger in bit 0.
- R4: sdo_oe stays high for exactly N×26 consecutive cycles per token visit, and every expected bit has been sent before the token leaves.
- R5: tok_out is a one-cycle pulse per token visit, and sdo_oe is low in the cycle in which tok_out is high.
- R6: sdo is 0 whenever sdo_oe is 0.
- R7: The event count is captured when the token arrives. Changing ev_count during a readout does not change the number of words sent.
- R8: An event count above the store depth of 16 is treated as 16.
- R9: A tok_in pulse that arrives while the chip is already reading out is ignored: one tok_out only, and the word stream is unchanged.
- R10: rd_done goes high in the same cycle as tok_out when chain_tail is 1, stays high until the next tok_in is sampled, and stays 0 when chain_tail is 0.
- R11: ram_rd_en is high for exactly one cycle per word sent, never in two consecutive cycles, and never for a chip with zero events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_in | input | 1 | Token arriving from the previous chip |
| ev_count | input | 5 | Number of events stored (sampled at token arrival) |
| chain_tail | input | 1 | High on the last chip of the chain |
| ram_rd_en | output | 1 | Event RAM read strobe |
| ram_addr | output | 4 | Event RAM read address |
| ram_data | input | 26 | Event RAM read data, valid one cycle after the strobe |
| sdo | output | 1 | Serial data onto the shared line |
| sdo_oe | output | 1 | Drive enable for the shared line |
| tok_out | output | 1 | Token pulse to the next chip |
| rd_done | output | 1 | Whole-chain readout complete (tail chip only) |

## Verification
Two functions can coincide. The first is the hand-over of the line: the last bit leaves while the token pulse and the enable drop must land on the same edge. The second is an incoming token during a busy readout, which must not restart or lengthen the stream. The bench provokes both. It pulses tok_in in the middle of a multi-word readout and changes ev_count while the words stream out. It then judges the result by counting enabled cycles against N×26, comparing every bit against a queue of expected bits, and requiring exactly one tok_out with the enable already low in that cycle.

// File: rtl/tkr_pkg.sv
// Shared types for the token readout controller.
// Assumes: event words are stored already packed in the layout below.
package tkr_pkg;

    // Packed event word, most-significant field first on the line.
    typedef struct packed {
        logic [11:0] bcid;
        logic [11:0] charge;
        logic        gain_lo;
        logic        trig;
    } evt_word_t;

    localparam int EVT_W = $bits(evt_word_t);

    // Controller phases for one token visit.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_SHIFT = 2'd3
    } rd_state_e;

endpackage

// File: rtl/tkr_seq.sv
// Token sequencer: captures the event count at token arrival, walks the
// word index, emits the outgoing token and the chain-completion flag.
// Assumes: bit_last comes from the serializer and marks the final bit of a word.
module tkr_seq #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tok_in,
    input  logic [CNT_W-1:0]     ev_count,
    input  logic                 chain_tail,
    input  logic                 bit_last,
    output tkr_pkg::rd_state_e   state,
    output logic [ADDR_W-1:0]    wcnt,
    output logic                 more,
    output logic                 tok_out,
    output logic                 rd_done
);
    import tkr_pkg::*;

    logic [CNT_W-1:0] nev;
    logic [CNT_W-1:0] cnt_clamped;
    logic [CNT_W:0]   nxt_idx;

    // Limit the requested count to the store depth.
    always_comb begin
        cnt_clamped = (ev_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : ev_count;
    end

    // Tell whether another word follows the current one.
    always_comb begin
        nxt_idx = (CNT_W+1)'(wcnt) + 1'b1;
        more    = nxt_idx < {1'b0, nev};
    end

    // Phase machine, token pulse and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nev     <= '0;
            wcnt    <= '0;
            tok_out <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            tok_out <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tok_in) begin
                        nev     <= cnt_clamped;
                        wcnt    <= '0;
                        rd_done <= 1'b0;
                        if (cnt_clamped == '0) begin
                            tok_out <= 1'b1;
                            rd_done <= chain_tail;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD:  state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (bit_last) begin
                        if (more) begin
                            wcnt <= wcnt + 1'b1;
                        end else begin
                            state   <= ST_IDLE;
                            tok_out <= 1'b1;
                            rd_done <= chain_tail;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the captured count never exceeds the store depth.
    a_r8_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        nev <= CNT_W'(DEPTH));

    // R9: a token arriving while busy does not produce an extra token.
    a_r9_busy_token_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && state == ST_FETCH) |=> !tok_out);

endmodule

// File: rtl/tkr_fetch.sv
// RAM read generator: one read for the first word on token arrival and a
// prefetch of each following word two bits before the current word ends.
// Assumes: RAM returns data one cycle after the strobe; word width >= 3.
module tkr_fetch #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tkr_pkg::rd_state_e state,
    input  logic               bit_pre,
    input  logic               more,
    input  logic [ADDR_W-1:0]  wcnt,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  addr
);
    import tkr_pkg::*;

    // Strobe and address for the word needed next.
    always_comb begin
        rd_en = 1'b0;
        addr  = '0;
        if (state == ST_FETCH) begin
            rd_en = 1'b1;
        end else if (state == ST_SHIFT && bit_pre && more) begin
            rd_en = 1'b1;
            addr  = wcnt + 1'b1;
        end
    end

    // R11: reads are isolated single-cycle strobes.
    a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

endmodule

// File: rtl/tkr_ser.sv
// Word serializer: loads a word and presents it MSB first, one bit per clock.
// Assumes: load and shift_en are produced by the sequencer phases.
module tkr_ser #(
    parameter int WORD_W = tkr_pkg::EVT_W,
    parameter int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic              msb,
    output logic              bit_pre,
    output logic              bit_last
);
    logic [WORD_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;

    // Shift register and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (load) begin
            shreg  <= din;
            bitcnt <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            if (!bit_last) bitcnt <= bitcnt + 1'b1;
        end
    end

    // Position flags for prefetch and word end.
    always_comb begin
        msb      = shreg[WORD_W-1];
        bit_pre  = bitcnt == BIT_W'(WORD_W - 2);
        bit_last = bitcnt == BIT_W'(WORD_W - 1);
    end

    // R3: a word that ends without a reload ends the shifting phase.
    a_r3_word_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && bit_last && !load) |=> !shift_en);

endmodule

// File: rtl/tkr_chain_readout.sv
// Per-chip readout controller for a token-passing chain on one shared
// serial line. Drives the line only between token arrival and hand-over.
// Assumes: single clock, RAM with one-cycle read latency, chain_tail static.
module tkr_chain_readout #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = tkr_pkg::EVT_W,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic [CNT_W-1:0]  ev_count,
    input  logic              chain_tail,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [WORD_W-1:0] ram_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              tok_out,
    output logic              rd_done
);
    import tkr_pkg::*;

    rd_state_e         state;
    logic [ADDR_W-1:0] wcnt;
    logic              more;
    logic              bit_pre;
    logic              bit_last;
    logic              msb;
    logic              load;
    logic              shifting;

    tkr_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .ev_count(ev_count),
        .chain_tail(chain_tail), .bit_last(bit_last), .state(state),
        .wcnt(wcnt), .more(more), .tok_out(tok_out), .rd_done(rd_done)
    );

    tkr_fetch #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .state(state), .bit_pre(bit_pre),
        .more(more), .wcnt(wcnt), .rd_en(ram_rd_en), .addr(ram_addr)
    );

    tkr_ser #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shifting),
        .din(ram_data), .msb(msb), .bit_pre(bit_pre), .bit_last(bit_last)
    );

    // Load on the first word and on each back-to-back successor.
    always_comb begin
        shifting = state == ST_SHIFT;
        load     = (state == ST_LOAD) || (shifting && bit_last && more);
    end

    // Line drive: enable only while shifting, data gated by the enable.
    always_comb begin
        sdo_oe = shifting;
        sdo    = shifting & msb;
    end

    // R5: the line is released in the token hand-over cycle.
    a_r5_release_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> !sdo_oe);

    // R4: the enable only ever falls together with the token pulse.
    a_r4_oe_ends_with_token: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> tok_out);

    // R10: the completion flag rises only with a hand-over at the tail.
    a_r10_done_at_tail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> (tok_out && chain_tail));

endmodule

// File: tb/sim_tkr_chain_readout.sv
// Scoreboard bench: the driver queues expected bits, the monitor pops them.
module sim_tkr_chain_readout;
    localparam int W     = tkr_pkg::EVT_W;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_in = 1'b0;
    logic [4:0]  ev_count = '0;
    logic        chain_tail = 1'b0;
    logic        ram_rd_en;
    logic [3:0]  ram_addr;
    logic [W-1:0] ram_data;
    logic        sdo, sdo_oe, tok_out, rd_done;

    logic [W-1:0] mem [DEPTH];
    bit           exp_q [$];
    int checks = 0, fails = 0;
    int oe_cycles = 0, tok_seen = 0, reads = 0, cyc = 0;
    bit running = 1'b0;
    bit prev_tok = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tkr_chain_readout u0 (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .ev_count(ev_count),
        .chain_tail(chain_tail), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
        .ram_data(ram_data), .sdo(sdo), .sdo_oe(sdo_oe), .tok_out(tok_out),
        .rd_done(rd_done)
    );

    // Event RAM model with one cycle of read latency.
    always_ff @(posedge clk) if (ram_rd_en) ram_data <= mem[ram_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [W-1:0] mk_word(int i, int s);
        tkr_pkg::evt_word_t w;
        w.bcid    = 12'(s * 37 + i * 101);
        w.charge  = 12'(s * 11 + i * 29 + 5);
        w.gain_lo = 1'(i);
        w.trig    = 1'(s + i + 1);
        return w;
    endfunction

    // Monitor: compares line bits against the queue, counts enables and tokens.
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (ram_rd_en) reads++;
            if (sdo_oe) begin
                oe_cycles++;
                if (exp_q.size() == 0) check(1'b0, "R4 extra bit", 1, 0);
                else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(sdo == e, "R3 bit", int'(sdo), int'(e));
                end
            end else begin
                check(sdo == 1'b0, "R6 quiet line", int'(sdo), 0);
            end
            if (tok_out) begin
                tok_seen++;
                check(!sdo_oe, "R5 oe at pass", int'(sdo_oe), 0);
                check(!prev_tok, "R5 pulse width", int'(prev_tok), 0);
                check(exp_q.size() == 0, "R4 bits left at pass", exp_q.size(), 0);
            end
            prev_tok = tok_out;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", cyc, 150000);
            summary();
        end
    end

    // Driver: one token visit with expected bits queued ahead of time.
    task automatic run_case(input int cnt, input bit tail, input bit wiggle,
                            input bit extra_tok, input int seed);
        int nexp;
        int waited;
        nexp = (cnt > DEPTH) ? DEPTH : cnt;
        for (int i = 0; i < DEPTH; i++) mem[i] = mk_word(i, seed);
        for (int i = 0; i < nexp; i++)
            for (int b = W - 1; b >= 0; b--) exp_q.push_back(mem[i][b]);
        oe_cycles = 0; tok_seen = 0; reads = 0;
        @(negedge clk);
        ev_count = 5'(cnt); chain_tail = tail; tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
        #1;
        if (nexp == 0) begin
            check(tok_out == 1'b1, "R2 immediate token", int'(tok_out), 1);
        end else begin
            check(tok_out == 1'b0, "R3 no early token", int'(tok_out), 0);
            check(rd_done == 1'b0, "R10 done cleared on token", int'(rd_done), 0);
            @(negedge clk); @(negedge clk); #1;
            check(sdo_oe == 1'b1, "R3 enable latency", int'(sdo_oe), 1);
            if (wiggle) ev_count = 5'd1;
            if (extra_tok) begin
                repeat (10) @(negedge clk);
                tok_in = 1'b1;
                @(negedge clk);
                tok_in = 1'b0;
            end
        end
        waited = 0;
        while (tok_seen == 0 && waited < 1000) begin
            @(negedge clk); #1; waited++;
        end
        repeat (6) @(negedge clk);
        #1;
        check(tok_seen == 1, extra_tok ? "R9 single token" : "R5 single token", tok_seen, 1);
        check(oe_cycles == nexp * W, cnt > DEPTH ? "R8 clamped length" :
              (wiggle ? "R7 latched count" : "R4 enable length"), oe_cycles, nexp * W);
        check(exp_q.size() == 0, "R3 all bits sent", exp_q.size(), 0);
        check(reads == nexp, "R11 read count", reads, nexp);
        check(rd_done == tail, "R10 done flag", int'(rd_done), int'(tail));
        if (nexp == 0) check(oe_cycles == 0, "R2 no drive", oe_cycles, 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check({tok_out, sdo, sdo_oe, rd_done, ram_rd_en} == 5'b0, "R1 reset state",
              int'({tok_out, sdo, sdo_oe, rd_done, ram_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check({tok_out, sdo, sdo_oe, rd_done, ram_rd_en} == 5'b0, "R1 after reset",
              int'({tok_out, sdo, sdo_oe, rd_done, ram_rd_en}), 0);
        running = 1'b1;
        run_case(3,  1'b0, 1'b0, 1'b0, 1);   // R3 R4 basic stream
        run_case(0,  1'b0, 1'b0, 1'b0, 2);   // R2 empty chip
        run_case(1,  1'b1, 1'b0, 1'b0, 3);   // R10 tail with data
        run_case(20, 1'b0, 1'b0, 1'b0, 4);   // R8 clamp
        run_case(5,  1'b0, 1'b1, 1'b0, 5);   // R7 count changed mid-stream
        run_case(4,  1'b1, 1'b0, 1'b1, 6);   // R9 token while busy
        run_case(0,  1'b1, 1'b0, 1'b0, 7);   // R2 R10 empty tail
        run_case(16, 1'b0, 1'b0, 1'b0, 8);   // R4 full store
        running = 1'b0;
        finished = 1'b1;
        summary();
    end

endmodule